// File: doc/BRIEF.md
# Quadword Burst Memory Responder

This block sits on a processor system bus as a memory target. It watches the cycle-start strobe. At that clock it captures the memory/IO select, the transfer direction, the burst request, the byte enables and the quadword address. It then answers from a small internal array of quadwords and uses one active-low ready line. For a read, ready marks the clock in which the data is valid. For a write, ready marks the clock in which the data is taken.

A programmable wait count delays the first ready of a cycle. A burst transfers four quadwords from one aligned four-quadword line. It starts at the requested quadword and wraps inside the line. By default the beats come one per clock, and a slow-burst input inserts one idle clock between beats. Cycles aimed at IO space are not answered. A second cycle-start strobe that arrives while a cycle is still open raises an error flag.

Top module: `qword_burst_mem`

## Requirements
- R1: A strobe sampled with `mem_io` low (IO space) is ignored: `rdy_n` stays high and no array location changes.
- R2: During every read ready clock (`rdy_n` low), `data_oe` is high and `rdata` equals the stored quadword for that beat.
- R3: With `wait_cfg` = W captured at the strobe clock, the first `rdy_n` low clock is W+1 clocks after the strobe clock. For W = 0 this is the clock right after the strobe.
- R4: A write beat stores `wdata` at the clock edge that ends its ready-low clock. Byte i (`wdata[8i+7:8i]`) is written only if `be_n[i]` was low at the strobe.
- R5: A strobe with `line_n` low starts a four-beat burst. Beat k uses quadword address {addr[AW-1:2], (addr[1:0]+k) mod 4}. With `slow_burst` low, `rdy_n` stays low for four consecutive clocks.
- R6: With `slow_burst` high at the strobe, exactly one `rdy_n` high clock separates consecutive burst beats.
- R7: A strobe with `line_n` high gives exactly one ready clock.
- R8: In the clock after the last ready of a cycle, `rdy_n` is high and `data_oe` is low. `data_oe` is never high outside an open read cycle.
- R9: A strobe low while a cycle is open sets `proto_err` high for the following clock. It starts no new cycle and does not disturb the open one.
- R10: After reset, `rdy_n` is high and `data_oe` and `proto_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Cycle-start strobe, active low |
| mem_io | input | 1 | Space select: 1 memory, 0 IO |
| wr | input | 1 | Direction: 1 write, 0 read |
| line_n | input | 1 | Burst request, active low |
| be_n | input | DW/8 | Byte-lane enables, active low |
| addr | input | AW | Quadword address |
| wdata | input | DW | Write data |
| wait_cfg | input | WW | Wait clocks before the first ready |
| slow_burst | input | 1 | Space burst beats one clock apart |
| rdata | output | DW | Read data, zero when not driven |
| data_oe | output | 1 | Read data drive enable |
| rdy_n | output | 1 | Transfer ready, active low |
| proto_err | output | 1 | Strobe seen while a cycle was open |

## Verification
The bench sweeps every wait count 0 to 3, both burst spacings, all four starting offsets inside a line, single and burst transfers, and reads and writes. Counting the gap before each ready separates wait-count errors from errors in burst spacing. Reads of every burst beat check the wrap-around stepping order. Writes use several byte-enable patterns and are later read back against an arithmetic byte-merge model, which shows whether disabled lanes were written. The bench also sends a strobe to IO space and a strobe that overlaps an open cycle. Reading the array afterwards, and watching ready, shows that neither one started a transfer.

// File: rtl/qbm_pkg.sv
package qbm_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_WAIT = 2'd1,
      S_XFER = 2'd2
   } seq_st_e;

   localparam int LINE_BEATS = 4;
   localparam int BEAT_W     = 2;
endpackage

// File: rtl/qbm_decode.sv
module qbm_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic ads_n,
   input  logic mem_io,
   input  logic busy,
   output logic start,
   output logic proto_err
);
   logic strobe;

   assign strobe = !ads_n;
   assign start  = strobe && mem_io && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) proto_err <= 1'b0;
      else        proto_err <= strobe && busy;
   end
endmodule

// File: rtl/qbm_sequencer.sv
module qbm_sequencer #(
   parameter int AW      = 4,
   parameter int WW      = 3,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [WW-1:0] wait_cfg,
   input  logic          burst_in,
   input  logic          wr_in,
   input  logic          slow_in,
   input  logic [AW-1:0] addr_in,
   output logic          busy,
   output logic          xfer,
   output logic          rdy,
   output logic          wr_q,
   output logic [AW-1:0] beat_addr
);
   import qbm_pkg::*;

   seq_st_e                  st;
   logic [WW-1:0]            cnt;
   logic [BEAT_W-1:0]        beat;
   logic                     burst_q;
   logic                     slow_q;
   logic [AW-1:0]            base_q;
   logic                     slow_eff;
   logic                     last_beat;

   generate
      if (SLOW_EN) begin : g_slow
         assign slow_eff = slow_in;
      end else begin : g_fast
         assign slow_eff = 1'b0;
      end
   endgenerate

   assign busy      = (st != S_IDLE);
   assign xfer      = (st == S_XFER);
   assign last_beat = !burst_q || (beat == BEAT_W'(LINE_BEATS - 1));
   assign beat_addr = {base_q[AW-1:BEAT_W], base_q[BEAT_W-1:0] + beat};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         beat    <= '0;
         rdy     <= 1'b0;
         burst_q <= 1'b0;
         slow_q  <= 1'b0;
         wr_q    <= 1'b0;
         base_q  <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  burst_q <= burst_in;
                  slow_q  <= slow_eff;
                  wr_q    <= wr_in;
                  base_q  <= addr_in;
                  beat    <= '0;
                  cnt     <= wait_cfg;
                  if (wait_cfg == '0) begin
                     st  <= S_XFER;
                     rdy <= 1'b1;
                  end else begin
                     st  <= S_WAIT;
                     rdy <= 1'b0;
                  end
               end
            end
            S_WAIT: begin
               cnt <= cnt - 1'b1;
               if (cnt == WW'(1)) begin
                  st  <= S_XFER;
                  rdy <= 1'b1;
               end
            end
            S_XFER: begin
               if (rdy) begin
                  if (last_beat) begin
                     st   <= S_IDLE;
                     rdy  <= 1'b0;
                     beat <= '0;
                  end else begin
                     beat <= beat + 1'b1;
                     rdy  <= !slow_q;
                  end
               end else begin
                  rdy <= 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qbm_store.sv
module qbm_store #(
   parameter int AW = 4,
   parameter int DW = 64
) (
   input  logic            clk,
   input  logic            we,
   input  logic [DW/8-1:0] lane_n,
   input  logic [AW-1:0]   idx,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rword
);
   localparam int LANES = DW / 8;
   localparam int DEPTH = 1 << AW;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [7:0] bank [DEPTH];

         always_ff @(posedge clk) begin
            if (we && !lane_n[g]) bank[idx] <= wdata[8*g +: 8];
         end

         assign rword[8*g +: 8] = bank[idx];
      end
   endgenerate
endmodule

// File: rtl/qword_burst_mem.sv
module qword_burst_mem #(
   parameter int AW      = 4,
   parameter int DW      = 64,
   parameter int WW      = 3,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ads_n,
   input  logic            mem_io,
   input  logic            wr,
   input  logic            line_n,
   input  logic [DW/8-1:0] be_n,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   input  logic [WW-1:0]   wait_cfg,
   input  logic            slow_burst,
   output logic [DW-1:0]   rdata,
   output logic            data_oe,
   output logic            rdy_n,
   output logic            proto_err
);
   localparam int LANES = DW / 8;

   initial begin
      if (DW % 8 != 0) $error("DW must be a whole number of bytes");
      if (AW < qbm_pkg::BEAT_W) $error("AW must cover one burst line");
      if (WW < 1) $error("WW must be at least 1");
   end

   logic             busy;
   logic             start;
   logic             xfer;
   logic             rdy;
   logic             wr_q;
   logic [AW-1:0]    beat_addr;
   logic [LANES-1:0] be_q;
   logic [DW-1:0]    rword;

   qbm_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ads_n     (ads_n),
      .mem_io    (mem_io),
      .busy      (busy),
      .start     (start),
      .proto_err (proto_err)
   );

   qbm_sequencer #(.AW(AW), .WW(WW), .SLOW_EN(SLOW_EN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .wait_cfg  (wait_cfg),
      .burst_in  (!line_n),
      .wr_in     (wr),
      .slow_in   (slow_burst),
      .addr_in   (addr),
      .busy      (busy),
      .xfer      (xfer),
      .rdy       (rdy),
      .wr_q      (wr_q),
      .beat_addr (beat_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     be_q <= '1;
      else if (start) be_q <= be_n;
   end

   qbm_store #(.AW(AW), .DW(DW)) u_mem (
      .clk    (clk),
      .we     (rdy && wr_q),
      .lane_n (be_q),
      .idx    (beat_addr),
      .wdata  (wdata),
      .rword  (rword)
   );

   assign rdy_n   = !rdy;
   assign data_oe = xfer && !wr_q;
   assign rdata   = data_oe ? rword : '0;
endmodule

// File: rtl/qbm_chk.sv
module qbm_chk #(
   parameter int WW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ads_n,
   input logic          mem_io,
   input logic [WW-1:0] wait_cfg,
   input logic          rdy_n,
   input logic          data_oe,
   input logic          proto_err,
   input logic          busy
);
   // R3
   zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && mem_io && !busy && wait_cfg == '0) |=> !rdy_n);

   // R1
   io_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && !mem_io && !busy) |=> (rdy_n && !busy));

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rdy_n && !data_oe));

   // R9
   overlap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && busy) |=> proto_err);

   // R9
   no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ads_n || !busy) |=> !proto_err);
endmodule

bind qword_burst_mem qbm_chk #(.WW(WW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ads_n     (ads_n),
   .mem_io    (mem_io),
   .wait_cfg  (wait_cfg),
   .rdy_n     (rdy_n),
   .data_oe   (data_oe),
   .proto_err (proto_err),
   .busy      (busy)
);

// File: tb/qword_burst_mem_test.sv
module qword_burst_mem_test;
   localparam int AW = 4;
   localparam int DW = 64;
   localparam int WW = 3;
   localparam int NQ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ads_n = 1'b1;
   logic          mem_io = 1'b1;
   logic          wr = 1'b0;
   logic          line_n = 1'b1;
   logic [7:0]    be_n = 8'hFF;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [WW-1:0] wait_cfg = '0;
   logic          slow_burst = 1'b0;
   logic [DW-1:0] rdata;
   logic          data_oe;
   logic          rdy_n;
   logic          proto_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] model [NQ];

   always #2 clk = ~clk;

   qword_burst_mem #(.AW(AW), .DW(DW), .WW(WW)) uut (
      .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mem_io(mem_io), .wr(wr),
      .line_n(line_n), .be_n(be_n), .addr(addr), .wdata(wdata),
      .wait_cfg(wait_cfg), .slow_burst(slow_burst), .rdata(rdata),
      .data_oe(data_oe), .rdy_n(rdy_n), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int seed, input int b);
      return 64'h9E37_79B9_7F4A_7C15 * 64'(seed * 8 + b + 1) ^ 64'(seed);
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] nw,
                                           input logic [7:0] ben);
      logic [DW-1:0] r = old;
      for (int i = 0; i < 8; i++)
         if (!ben[i]) r[8*i +: 8] = nw[8*i +: 8];
      return r;
   endfunction

   // one complete memory cycle, driven and sampled on falling edges
   task automatic run(input logic [AW-1:0] a, input bit w, input bit burst,
                      input logic [7:0] ben, input int wt, input bit slow,
                      input int seed);
      int nb = burst ? 4 : 1;
      ads_n = 1'b0; mem_io = 1'b1; wr = w; line_n = !burst; be_n = ben;
      addr = a; wait_cfg = WW'(wt); slow_burst = slow; wdata = pat(seed, 0);
      @(negedge clk);
      ads_n = 1'b1;
      for (int b = 0; b < nb; b++) begin
         int gaps = 0;
         logic [AW-1:0] ba;
         while (rdy_n && gaps < 40) begin
            gaps++;
            @(negedge clk);
         end
         ba = {a[AW-1:2], a[1:0] + 2'(b)};
         if (b == 0)
            chk(gaps == wt, "R3 first ready delay", 64'(gaps), 64'(wt));
         else if (slow)
            chk(gaps == 1, "R6 slow burst gap", 64'(gaps), 64'd1);
         else
            chk(gaps == 0, "R5 fast burst gap", 64'(gaps), 64'd0);
         if (!w) begin
            chk(rdata === model[ba] && data_oe, "R2 R5 read beat data",
                rdata, model[ba]);
         end else begin
            model[ba] = merge(model[ba], wdata, ben);
         end
         @(negedge clk);
         if (w) wdata = pat(seed, b + 1);
      end
      chk(rdy_n === 1'b1 && data_oe === 1'b0, "R7 R8 end of cycle release",
          {62'd0, rdy_n, data_oe}, 64'd2);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed = 1;
      repeat (3) @(negedge clk);
      // R10
      chk(rdy_n === 1'b1 && data_oe === 1'b0 && proto_err === 1'b0,
          "R10 reset outputs", {61'd0, rdy_n, data_oe, proto_err}, 64'd4);
      rst_n = 1'b1;
      @(negedge clk);

      // fill whole array with full-width single writes
      for (int q = 0; q < NQ; q++) begin
         run(AW'(q), 1'b1, 1'b0, 8'h00, 0, 1'b0, seed);
         seed++;
      end
      for (int q = 0; q < NQ; q++) run(AW'(q), 1'b0, 1'b0, 8'hFF, q % 4, 1'b0, 0);

      // sweep waits, spacing, offsets, direction, lane masks
      for (int wt = 0; wt < 4; wt++)
         for (int sl = 0; sl < 2; sl++)
            for (int off = 0; off < 4; off++) begin
               logic [AW-1:0] a = AW'(((wt * 2 + sl) * 4 + off) % NQ);
               logic [7:0] m = 8'hFF >> (off + wt);
               m = m ^ {sl[0], 7'd0} ^ {4'd0, 4'(off)};
               // R4 burst write with lane mask, then reads
               run(a, 1'b1, 1'b1, m, wt, sl[0], seed); seed++;
               run(a, 1'b0, 1'b1, 8'hFF, wt, sl[0], 0);
               // R7 single write/read
               run(a ^ AW'(5), 1'b1, 1'b0, ~m, wt, sl[0], seed); seed++;
               run(a ^ AW'(5), 1'b0, 1'b0, 8'hFF, wt, sl[0], 0);
            end

      // R1 IO-space write is ignored
      ads_n = 1'b0; mem_io = 1'b0; wr = 1'b1; line_n = 1'b1; be_n = 8'h00;
      addr = AW'(3); wait_cfg = '0; wdata = '1;
      @(negedge clk);
      ads_n = 1'b1; mem_io = 1'b1;
      for (int k = 0; k < 4; k++) begin
         chk(rdy_n === 1'b1, "R1 no ready for IO cycle", 64'(rdy_n), 64'd1);
         @(negedge clk);
      end
      run(AW'(3), 1'b0, 1'b0, 8'hFF, 0, 1'b0, 0);

      // R9 overlapping strobe during an open read with two waits
      ads_n = 1'b0; mem_io = 1'b1; wr = 1'b0; line_n = 1'b1; addr = AW'(9);
      wait_cfg = WW'(2);
      @(negedge clk);
      ads_n = 1'b0; addr = AW'(2); wr = 1'b1; wdata = '0; be_n = 8'h00;
      @(negedge clk);
      ads_n = 1'b1;
      chk(proto_err === 1'b1, "R9 overlap flagged", 64'(proto_err), 64'd1);
      chk(rdy_n === 1'b1, "R9 open cycle wait kept", 64'(rdy_n), 64'd1);
      @(negedge clk);
      chk(proto_err === 1'b0, "R9 flag lasts one clock", 64'(proto_err), 64'd0);
      chk(rdy_n === 1'b0 && rdata === model[9], "R9 open read completes",
          rdata, model[9]);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(rdy_n === 1'b1, "R9 no second cycle started", 64'(rdy_n), 64'd1);
      end
      run(AW'(2), 1'b0, 1'b0, 8'hFF, 0, 1'b0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule